// File: doc/BRIEF.md
# Endpoint NAK Interrupt Aggregator

This block turns per-endpoint "IN token answered with NAK" strobes from a USB device controller into a CPU interrupt. Each of six endpoint slots latches its own request bit and has its own enable bit. The enabled requests are ORed together. A rising edge of that OR arms a single summary request bit, which has its own enable. The CPU interrupt line is a registered copy of "summary request AND summary enable".

Firmware reaches four byte-wide registers over a plain write-strobe bus with combinational read data. Request bits, both per-slot and summary, are cleared by writing 1. Because the summary is armed by an edge of the OR, a cleared summary stays quiet until every per-slot request has been serviced and a fresh NAK arrives. Firmware therefore clears the slot bits first and the summary bit last. A NAK strobe counts only when the controller marks that endpoint as a BULK or INTERRUPT IN endpoint.

Top module: `nak_irq_agg`

## Requirements
- R1: After reset every enable, request and summary bit reads 0 and `cpu_irq` is 0.
- R2: Slot bit i maps to endpoints EP0, EP1, EP2, EP4, EP6, EP8 for i = 0..5. A `nak_strobe[i]` pulse with `nak_qualify[i]`=1 sets request bit i at the next clock edge. The request register is at offset 1, bits 5:0.
- R3: A strobe on a slot whose `nak_qualify` bit is 0 leaves that slot's request bit unchanged.
- R4: Writing 1 to a request bit at offset 1 clears it, and writing 0 leaves it unchanged. When a qualified strobe and a write-1 clear hit the same slot in the same cycle, the bit ends set.
- R5: The slot enables at offset 0, bits 5:0, and the summary enable at offset 2, bit 0, are read/write. Unused bit positions, and addresses outside offsets 0..3, read 0.
- R6: The summary request bit (offset 3, bit 0) sets on the clock edge after OR(request AND enable) goes from 0 to 1.
- R7: Writing 1 to offset 3 bit 0 clears the summary bit. The summary bit does not set again while any enabled request remains set. It sets again only after the OR has returned to 0 and a new enabled request arrives.
- R8: `cpu_irq` equals, one cycle later, the AND of the summary request bit and the summary enable bit.
- R9: A request on a disabled slot is still latched but does not arm the summary. Enabling that slot later does arm the summary, provided no other enabled request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nak_strobe | input | 6 | One-cycle pulse per slot: endpoint NAKed a host IN token |
| nak_qualify | input | 6 | Per slot: endpoint configured as BULK or INTERRUPT IN |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |

## Verification
The hardest case to reach is a summary bit held low while slot requests are still pending. It takes a slot request raised, the summary cleared under it, and a second NAK on another slot, all before any slot is serviced. The bench builds this from ordered register writes. It then clears the slots one by one and shows the summary returns only after the last clear and a new NAK. The collision of a strobe with a write-1 clear on the same slot is driven in a single cycle.

// File: rtl/nak_agg_pkg.sv
package nak_agg_pkg;
  // Register offsets from the block base address
  localparam int OFS_SLOT_EN  = 0;
  localparam int OFS_SLOT_REQ = 1;
  localparam int OFS_SUM_EN   = 2;
  localparam int OFS_SUM_REQ  = 3;
  localparam int DATA_W       = 8;
  typedef logic [DATA_W-1:0] reg_byte_t;
endpackage

// File: rtl/nak_reg_decode.sv
module nak_reg_decode
  import nak_agg_pkg::*;
#(
  parameter int NS        = 6,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 0
) (
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  reg_byte_t         reg_wdata,
  input  logic [NS-1:0]     slot_en,
  input  logic [NS-1:0]     slot_req,
  input  logic              sum_en,
  input  logic              sum_req,
  output logic              slot_en_we,
  output logic [NS-1:0]     slot_clr,
  output logic              sum_en_we,
  output logic              sum_clr,
  output reg_byte_t         reg_rdata
);
  localparam logic [ADDR_W-1:0] A_SEN  = ADDR_W'(BASE_ADDR + OFS_SLOT_EN);
  localparam logic [ADDR_W-1:0] A_SREQ = ADDR_W'(BASE_ADDR + OFS_SLOT_REQ);
  localparam logic [ADDR_W-1:0] A_GEN  = ADDR_W'(BASE_ADDR + OFS_SUM_EN);
  localparam logic [ADDR_W-1:0] A_GREQ = ADDR_W'(BASE_ADDR + OFS_SUM_REQ);

  logic hit_sen, hit_sreq, hit_gen, hit_greq;
  assign hit_sen  = (reg_addr == A_SEN);
  assign hit_sreq = (reg_addr == A_SREQ);
  assign hit_gen  = (reg_addr == A_GEN);
  assign hit_greq = (reg_addr == A_GREQ);

  assign slot_en_we = reg_wr && hit_sen;
  assign sum_en_we  = reg_wr && hit_gen;
  assign slot_clr   = (reg_wr && hit_sreq) ? reg_wdata[NS-1:0] : '0;
  assign sum_clr    = reg_wr && hit_greq && reg_wdata[0];

  always_comb begin
    reg_rdata = '0;
    if (hit_sen)  reg_rdata[NS-1:0] = slot_en;
    if (hit_sreq) reg_rdata[NS-1:0] = slot_req;
    if (hit_gen)  reg_rdata[0]      = sum_en;
    if (hit_greq) reg_rdata[0]      = sum_req;
  end
endmodule

// File: rtl/nak_slot_bank.sv
module nak_slot_bank
  import nak_agg_pkg::*;
#(
  parameter int NS = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] nak_strobe,
  input  logic [NS-1:0] nak_qualify,
  input  logic          en_we,
  input  logic [NS-1:0] en_wdata,
  input  logic [NS-1:0] clr,
  output logic [NS-1:0] slot_en,
  output logic [NS-1:0] slot_req,
  output logic          any_armed
);
  logic [NS-1:0] hit;

  for (genvar i = 0; i < NS; i++) begin : g_slot
    assign hit[i] = nak_strobe[i] & nak_qualify[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_req[i] <= 1'b0;
        slot_en[i]  <= 1'b0;
      end else begin
        // a new NAK beats a same-cycle clear
        if (hit[i])      slot_req[i] <= 1'b1;
        else if (clr[i]) slot_req[i] <= 1'b0;
        if (en_we)       slot_en[i]  <= en_wdata[i];
      end
    end
  end

  assign any_armed = |(slot_req & slot_en);

  // R3 / R2: a request bit only rises on a qualified strobe
  assert_no_unqualified_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((slot_req & ~$past(slot_req) & ~$past(nak_strobe & nak_qualify)) == '0));

  // R4: a clear without a colliding strobe empties the bit
  assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~(nak_strobe & nak_qualify))) |=>
      ((slot_req & $past(clr & ~(nak_strobe & nak_qualify))) == '0));

  // R4: set wins over clear
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(nak_strobe & nak_qualify)) |=> ((slot_req & $past(nak_strobe & nak_qualify)) == $past(nak_strobe & nak_qualify)));
endmodule

// File: rtl/nak_summary.sv
module nak_summary (
  input  logic clk,
  input  logic rst_n,
  input  logic any_armed,
  input  logic sum_clr,
  input  logic sum_en_we,
  input  logic sum_en_wdata,
  output logic sum_req,
  output logic sum_en,
  output logic cpu_irq
);
  logic any_q;
  logic arm_rise;

  assign arm_rise = any_armed & ~any_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      any_q   <= 1'b0;
      sum_req <= 1'b0;
      sum_en  <= 1'b0;
      cpu_irq <= 1'b0;
    end else begin
      any_q <= any_armed;
      if (arm_rise)     sum_req <= 1'b1;
      else if (sum_clr) sum_req <= 1'b0;
      if (sum_en_we)    sum_en  <= sum_en_wdata;
      cpu_irq <= sum_req & sum_en;
    end
  end

  // R6 / R7: summary only rises after a rise of the armed OR
  assert_sum_rise_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sum_req) |-> $past(any_armed && !any_q));

  // R7: a clear without a rising edge drops the summary
  assert_sum_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_clr && !(any_armed && !any_q)) |=> !sum_req);

  // R8: interrupt line follows summary AND enable one cycle later
  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cpu_irq == $past(sum_req && sum_en)));
endmodule

// File: rtl/nak_irq_agg.sv
module nak_irq_agg
  import nak_agg_pkg::*;
#(
  parameter int NS        = 6,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NS-1:0]     nak_strobe,
  input  logic [NS-1:0]     nak_qualify,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              cpu_irq
);
  logic          slot_en_we, sum_en_we, sum_clr, any_armed;
  logic [NS-1:0] slot_clr, slot_en, slot_req;
  logic          sum_req, sum_en;

  nak_reg_decode #(.NS(NS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .slot_en   (slot_en),
    .slot_req  (slot_req),
    .sum_en    (sum_en),
    .sum_req   (sum_req),
    .slot_en_we(slot_en_we),
    .slot_clr  (slot_clr),
    .sum_en_we (sum_en_we),
    .sum_clr   (sum_clr),
    .reg_rdata (reg_rdata)
  );

  nak_slot_bank #(.NS(NS)) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .nak_strobe (nak_strobe),
    .nak_qualify(nak_qualify),
    .en_we      (slot_en_we),
    .en_wdata   (reg_wdata[NS-1:0]),
    .clr        (slot_clr),
    .slot_en    (slot_en),
    .slot_req   (slot_req),
    .any_armed  (any_armed)
  );

  nak_summary u_summary (
    .clk         (clk),
    .rst_n       (rst_n),
    .any_armed   (any_armed),
    .sum_clr     (sum_clr),
    .sum_en_we   (sum_en_we),
    .sum_en_wdata(reg_wdata[0]),
    .sum_req     (sum_req),
    .sum_en      (sum_en),
    .cpu_irq     (cpu_irq)
  );

  // R1: nothing pending right after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (slot_req == '0 && !sum_req && !cpu_irq));
endmodule

// File: tb/nak_irq_agg_bench.sv
module nak_irq_agg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] nak_strobe = '0;
  logic [5:0] nak_qualify = '1;
  logic [7:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       cpu_irq;

  int checks = 0;
  int fails  = 0;

  localparam logic [7:0] A_SEN = 8'd0, A_SREQ = 8'd1, A_GEN = 8'd2, A_GREQ = 8'd3;

  always #5 clk = ~clk;

  nak_irq_agg u_nak_irq_agg (
    .clk(clk), .rst_n(rst_n), .nak_strobe(nak_strobe), .nak_qualify(nak_qualify),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_irq(cpu_irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic strobe(input logic [5:0] m);
    @(negedge clk);
    nak_strobe = m;
    @(negedge clk);
    nak_strobe = '0;
  endtask

  task automatic cycle();
    @(negedge clk);
  endtask

  task automatic reset_all();
    wr(A_SREQ, 8'h3F);
    cycle();
    wr(A_GREQ, 8'h01);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(A_SEN, d);  check("R1 slot enable", d, 0);
    rd(A_SREQ, d); check("R1 slot request", d, 0);
    rd(A_GEN, d);  check("R1 summary enable", d, 0);
    rd(A_GREQ, d); check("R1 summary request", d, 0);
    check("R1 cpu_irq", cpu_irq, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(A_SEN, 8'hFF); rd(A_SEN, d); check("R5 enable width", d, 8'h3F);
    wr(A_SEN, 8'h15); rd(A_SEN, d); check("R5 enable pattern", d, 8'h15);
    wr(A_GEN, 8'hFE); rd(A_GEN, d); check("R5 summary enable bit0 only", d, 0);
    wr(A_GEN, 8'hFF); rd(A_GEN, d); check("R5 summary enable", d, 1);
    rd(8'd4, d);  check("R5 unused address", d, 0);
    rd(8'h80, d); check("R5 far address", d, 0);
    wr(A_GEN, 8'h00);
    wr(A_SEN, 8'h00);
  endtask

  task automatic t_slots();
    logic [7:0] d;
    nak_qualify = 6'b110111;
    strobe(6'b001000); rd(A_SREQ, d); check("R3 unqualified slot ignored", d, 0);
    nak_qualify = '1;
    for (int i = 0; i < 6; i++) begin
      strobe(6'(1 << i)); rd(A_SREQ, d); check("R2 slot bit position", d, 1 << i);
      wr(A_SREQ, 8'(1 << i));
    end
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    strobe(6'b100001);
    wr(A_SREQ, 8'h00); rd(A_SREQ, d); check("R4 write 0 keeps", d, 8'h21);
    wr(A_SREQ, 8'h20); rd(A_SREQ, d); check("R4 write 1 clears", d, 8'h01);
    // collision: strobe slot1 while clearing slots 0 and 1
    @(negedge clk);
    nak_strobe = 6'b000010; reg_addr = A_SREQ; reg_wdata = 8'h03; reg_wr = 1'b1;
    @(negedge clk);
    nak_strobe = '0; reg_wr = 1'b0;
    rd(A_SREQ, d); check("R4 set wins over clear", d, 8'h02);
    wr(A_SREQ, 8'h3F);
  endtask

  task automatic t_summary();
    logic [7:0] d;
    reset_all();
    wr(A_SEN, 8'h3F); wr(A_GEN, 8'h01);
    strobe(6'b000001);
    rd(A_GREQ, d); check("R6 summary not yet", d, 0);
    cycle(); rd(A_GREQ, d); check("R6 summary set after rise", d, 1);
    check("R8 irq lags summary", cpu_irq, 0);
    cycle(); check("R8 irq asserted", cpu_irq, 1);
    wr(A_GREQ, 8'h01); rd(A_GREQ, d); check("R7 summary cleared", d, 0);
    cycle(); check("R8 irq drops", cpu_irq, 0);
    strobe(6'b000100); cycle(); cycle();
    rd(A_GREQ, d); check("R7 no re-arm while pending", d, 0);
    wr(A_SREQ, 8'h01); cycle(); rd(A_GREQ, d); check("R7 still quiet, one left", d, 0);
    wr(A_SREQ, 8'h04); cycle(); rd(A_GREQ, d); check("R7 quiet after all cleared", d, 0);
    strobe(6'b010000); cycle();
    rd(A_GREQ, d); check("R7 re-arms on new NAK", d, 1);
    wr(A_GEN, 8'h00); cycle(); cycle(); check("R8 irq masked by summary enable", cpu_irq, 0);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    reset_all();
    wr(A_SEN, 8'h00);
    strobe(6'b000010); cycle(); cycle();
    rd(A_SREQ, d); check("R9 disabled request latched", d, 8'h02);
    rd(A_GREQ, d); check("R9 disabled request does not arm", d, 0);
    wr(A_SEN, 8'h02); cycle();
    rd(A_GREQ, d); check("R9 enabling pending request arms", d, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_slots();
    t_w1c();
    t_summary();
    t_disabled();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule